// File: doc/BRIEF.md
# External Bus Hold Arbitration Controller

This controller lets a local bus master share its external address/data bus with an outside master. The outside master asks for the bus by pulling an active-low hold request. The controller passes that request through a two-flop synchronizer. It lets any external cycle already running on the internal side finish, then turns off every bus driver. Only in the following clock does it grant the bus by pulling the active-low hold acknowledge.

While the bus is held, the internal side can still run work that does not touch the external bus. If that work needs the external bus, the controller pulls an active-low bus request toward the arbitration logic. When the outside master lets go of its request, the controller removes the acknowledge and the bus request. It waits one clock with the drivers still off, then drives the bus again.

A configuration enable decides whether hold requests are honoured. Software can clear it to keep the bus to itself. Once the enable has been seen high, a sticky mode output marks the three arbitration pins as dedicated to arbitration until reset. A ready output tells the internal side when it may start a new external cycle.

Top module: `busHoldArb`

## Requirements
- R1: The hold request is acted on only after a two-flop synchronizer. After holdReqN falls, the bus drivers stay on for at least the next two clock edges.
- R2: While cycleActive is high and the bus is still owned, an accepted request keeps all output enables at 1 and holdAckN at 1. Release starts at the first edge where cycleActive is low.
- R3: holdAckN goes low only in the clock after all output enables have already been 0 for a whole cycle.
- R4: While holdAckN is low, every bit of addrOe, dataOe and strobeOe is 0. strobeOe bit 0 is address latch, bit 1 read, bit 2 write and bit 3 byte-high enable.
- R5: busReqN is low exactly when holdAckN is low and needBus is high. It is high at all other times, including normal operation with needBus high.
- R6: While arbEnable is 0 and the bus is owned, hold requests are ignored: the output enables stay at 1 and holdAckN stays high.
- R7: arbPinMode goes to 1 in the clock after arbEnable is first sampled high, and stays 1 until reset, whatever arbEnable does later.
- R8: Clearing arbEnable during hold does not end the hold. The hold ends only when the synchronized request goes high.
- R9: On leaving hold, holdAckN and busReqN return high together while the output enables stay 0 for that clock. The enables return to 1 on the next clock.
- R10: startOk is 1 only while the bus is owned and no request is being accepted in that cycle. It is 0 from acceptance until the drivers are back on.
- R11: Reset puts the controller in the owned state: all enables 1, holdAckN and busReqN high, arbPinMode 0, startOk 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdReqN | input | 1 | Active-low hold request from the outside master (asynchronous) |
| arbEnable | input | 1 | Configuration enable for honouring hold requests |
| cycleActive | input | 1 | Internal side has an external bus cycle in progress |
| needBus | input | 1 | Internal side needs the external bus |
| holdAckN | output | 1 | Active-low hold acknowledge (grant) |
| busReqN | output | 1 | Active-low bus request, only during hold |
| startOk | output | 1 | Internal side may start a new external cycle |
| addrOe | output | ADDR_W | Address bus output enables |
| dataOe | output | DATA_W | Data bus output enables |
| strobeOe | output | STROBE_W | Strobe enables: latch, read, write, byte-high |
| arbPinMode | output | 1 | Sticky flag: arbitration pins are dedicated |

## Verification
The hold request is tried with an idle internal side, which gives the shortest release path. It is also tried with a long internal cycle, which shows whether the drain step waits for the cycle to end. A one-cycle request pulse shows that an accepted request is carried through to a full grant and return. Requests made with the enable low, both before and after it was ever set, separate the ignore behaviour from the sticky pin mode. Toggling needBus inside and outside hold, and clearing the enable in the middle of a hold, show that the bus request is confined to hold and that the hold lasts until the request is released.

// File: rtl/busHoldPkg.sv
package busHoldPkg;

  typedef enum logic [2:0] {
    ST_OWN    = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_FLOAT  = 3'd2,
    ST_HOLD   = 3'd3,
    ST_RETURN = 3'd4
  } holdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic driveBus;   // bus drivers enabled
    logic grant;      // hold acknowledge active
    logic reqWindow;  // bus request may be raised
  } holdStrobe_t;

endpackage

// File: rtl/busHoldCtrl.sv
module busHoldCtrl
  import busHoldPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSeen,
  input  logic        arbEnable,
  input  logic        cycleActive,
  output holdStrobe_t strobe,
  output logic        startOk
);

  holdState_t state, stateNext;
  logic accept;

  assign accept = reqSeen && arbEnable;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OWN:    if (accept) stateNext = cycleActive ? ST_DRAIN : ST_FLOAT;
      ST_DRAIN:  if (!cycleActive) stateNext = ST_FLOAT;
      ST_FLOAT:  stateNext = ST_HOLD;
      ST_HOLD:   if (!reqSeen) stateNext = ST_RETURN;
      ST_RETURN: stateNext = ST_OWN;
      default:   stateNext = ST_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OWN;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.driveBus  = (state == ST_OWN) || (state == ST_DRAIN);
    strobe.grant     = (state == ST_HOLD);
    strobe.reqWindow = (state == ST_HOLD);
    startOk          = (state == ST_OWN) && !accept;
  end

  // R2: an ongoing cycle keeps the drivers on
  p_drain_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_OWN || state == ST_DRAIN) && cycleActive) |=> strobe.driveBus);

  // R6: disabled arbitration leaves the owned state alone
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OWN && !arbEnable) |=> (state == ST_OWN));

  // R8: hold persists while the request is held
  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && reqSeen) |=> (state == ST_HOLD));

endmodule

// File: rtl/busHoldPath.sv
module busHoldPath
  import busHoldPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int STROBE_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                holdReqN,
  input  logic                arbEnable,
  input  logic                needBus,
  input  holdStrobe_t         strobe,
  output logic                reqSeen,
  output logic                holdAckN,
  output logic                busReqN,
  output logic [ADDR_W-1:0]   addrOe,
  output logic [DATA_W-1:0]   dataOe,
  output logic [STROBE_W-1:0] strobeOe,
  output logic                arbPinMode
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncChain;
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], holdReqN};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (arbEnable) armed <= 1'b1;
  end

  assign reqSeen    = ~syncChain[LAST];
  assign arbPinMode = armed;
  assign holdAckN   = ~strobe.grant;
  assign busReqN    = ~(strobe.reqWindow & needBus);
  assign addrOe     = {ADDR_W{strobe.driveBus}};
  assign dataOe     = {DATA_W{strobe.driveBus}};
  assign strobeOe   = {STROBE_W{strobe.driveBus}};

  // R3: grant only after a full cycle with drivers off
  p_grant_after_float_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdAckN) |-> ($past(addrOe) == '0 && $past(dataOe) == '0 && $past(strobeOe) == '0));

  // R4: bus floated throughout hold
  p_float_in_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !holdAckN |-> (addrOe == '0 && dataOe == '0 && strobeOe == '0));

  // R5: bus request only inside hold
  p_req_only_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busReqN |-> !holdAckN);

  // R7: pin mode is sticky
  p_sticky_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

  // R9: one idle clock before driving again
  p_return_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAckN) |-> (addrOe == '0) ##1 (addrOe == '1));

endmodule

// File: rtl/busHoldArb.sv
module busHoldArb
  import busHoldPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int STROBE_W    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                holdReqN,
  input  logic                arbEnable,
  input  logic                cycleActive,
  input  logic                needBus,
  output logic                holdAckN,
  output logic                busReqN,
  output logic                startOk,
  output logic [ADDR_W-1:0]   addrOe,
  output logic [DATA_W-1:0]   dataOe,
  output logic [STROBE_W-1:0] strobeOe,
  output logic                arbPinMode
);

  holdStrobe_t strobe;
  logic reqSeen;

  busHoldCtrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqSeen     (reqSeen),
    .arbEnable   (arbEnable),
    .cycleActive (cycleActive),
    .strobe      (strobe),
    .startOk     (startOk)
  );

  busHoldPath #(
    .SYNC_STAGES (SYNC_STAGES),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STROBE_W    (STROBE_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .holdReqN   (holdReqN),
    .arbEnable  (arbEnable),
    .needBus    (needBus),
    .strobe     (strobe),
    .reqSeen    (reqSeen),
    .holdAckN   (holdAckN),
    .busReqN    (busReqN),
    .addrOe     (addrOe),
    .dataOe     (dataOe),
    .strobeOe   (strobeOe),
    .arbPinMode (arbPinMode)
  );

endmodule

// File: tb/sim_busHoldArb.sv
`timescale 1ns/1ps
module sim_busHoldArb;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int SW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, holdReqN, arbEnable, cycleActive, needBus;
  logic holdAckN, busReqN, startOk, arbPinMode;
  logic [AW-1:0] addrOe;
  logic [DW-1:0] dataOe;
  logic [SW-1:0] strobeOe;

  busHoldArb #(.ADDR_W(AW), .DATA_W(DW), .STROBE_W(SW)) u0 (
    .clk(clk), .rstN(rstN), .holdReqN(holdReqN), .arbEnable(arbEnable),
    .cycleActive(cycleActive), .needBus(needBus), .holdAckN(holdAckN),
    .busReqN(busReqN), .startOk(startOk), .addrOe(addrOe), .dataOe(dataOe),
    .strobeOe(strobeOe), .arbPinMode(arbPinMode)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  string scen = "R11";

  // reference model: 0 owned, 1 draining, 2 floating, 3 hold, 4 returning
  int  mPhase = 0;
  bit  mArmed = 0;
  bit  syncQ[$] = '{1'b1, 1'b1};

  task automatic chk(string tag, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit seen;
    if (!rstN) begin
      mPhase = 0; mArmed = 0; syncQ = '{1'b1, 1'b1};
    end else begin
      seen = !syncQ[0];
      case (mPhase)
        0: if (seen && arbEnable) mPhase = cycleActive ? 1 : 2;
        1: if (!cycleActive) mPhase = 2;
        2: mPhase = 3;
        3: if (!seen) mPhase = 4;
        default: mPhase = 0;
      endcase
      if (arbEnable) mArmed = 1;
      syncQ.push_back(holdReqN);
      void'(syncQ.pop_front());
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      automatic bit drive = (mPhase <= 1);
      automatic bit ack   = (mPhase == 3);
      chk({scen, "/R3"}, "holdAckN", holdAckN, !ack);
      chk({scen, "/R5"}, "busReqN", busReqN, !(ack && needBus));
      chk({scen, "/R4"}, "addrOe", addrOe, drive ? {AW{1'b1}} : '0);
      chk({scen, "/R4"}, "dataOe", dataOe, drive ? {DW{1'b1}} : '0);
      chk({scen, "/R4"}, "strobeOe", strobeOe, drive ? {SW{1'b1}} : '0);
      chk({scen, "/R10"}, "startOk", startOk, (mPhase == 0) && !(!syncQ[0] && arbEnable));
      chk({scen, "/R7"}, "arbPinMode", arbPinMode, mArmed);
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; holdReqN = 1; arbEnable = 0; cycleActive = 0; needBus = 0;
    step(3);
    // R11: reset state
    chk("R11", "holdAckN", holdAckN, 1);
    chk("R11", "busReqN", busReqN, 1);
    chk("R11", "addrOe", addrOe, {AW{1'b1}});
    chk("R11", "arbPinMode", arbPinMode, 0);
    chk("R11", "startOk", startOk, 1);
    rstN = 1;
    step(2);

    // R6: requests ignored before enable, bus request quiet in normal operation
    scen = "R6";
    needBus = 1;
    holdReqN = 0;
    step(10);
    chk("R6", "addrOe", addrOe, {AW{1'b1}});
    chk("R6", "holdAckN", holdAckN, 1);
    chk("R5", "busReqN normal", busReqN, 1);
    holdReqN = 1;
    step(4);

    // R1: idle side, synchroniser delay then release and grant
    scen = "R1";
    arbEnable = 1;
    step(1);
    holdReqN = 0;
    step(2);
    chk("R1", "addrOe after two edges", addrOe, {AW{1'b1}});
    step(2);
    chk("R3", "holdAckN granted", holdAckN, 0);
    chk("R5", "busReqN in hold", busReqN, 0);
    needBus = 0;
    step(1);
    chk("R5", "busReqN no need", busReqN, 1);
    needBus = 1;
    scen = "R9";
    holdReqN = 1;
    step(3);
    chk("R9", "holdAckN released", holdAckN, 1);
    chk("R9", "addrOe gap", addrOe, '0);
    step(1);
    chk("R9", "addrOe back", addrOe, {AW{1'b1}});
    step(2);

    // R2: long internal cycle delays release
    scen = "R2";
    cycleActive = 1;
    holdReqN = 0;
    step(6);
    chk("R2", "dataOe during drain", dataOe, {DW{1'b1}});
    chk("R2", "holdAckN during drain", holdAckN, 1);
    chk("R10", "startOk during drain", startOk, 0);
    cycleActive = 0;
    step(2);
    chk("R2", "holdAckN after drain", holdAckN, 0);

    // R8: clearing enable mid-hold has no effect
    scen = "R8";
    arbEnable = 0;
    step(5);
    chk("R8", "holdAckN held", holdAckN, 0);
    holdReqN = 1;
    step(6);
    chk("R8", "holdAckN ended", holdAckN, 1);
    chk("R7", "arbPinMode sticky", arbPinMode, 1);

    // R6 again after arming
    scen = "R6";
    holdReqN = 0;
    step(6);
    chk("R6", "strobeOe armed ignore", strobeOe, {SW{1'b1}});
    chk("R7", "arbPinMode still", arbPinMode, 1);
    holdReqN = 1;
    step(3);

    // one-cycle pulse is carried through
    scen = "R10";
    arbEnable = 1;
    holdReqN = 0;
    step(1);
    holdReqN = 1;
    step(10);
    chk("R10", "startOk after pulse", startOk, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule